// File: doc/BRIEF.md
# Sample Record Filter

This block sits between the collection stage of an operation-sampling profiler and the writer that appends records to a memory buffer. Each time a sampled operation completes, the collector presents one record (operation class, a 16-bit event vector, its total latency counted from the cycle sampling started on it, and an opaque payload) with a one-cycle valid strobe. The filter decides whether that record is worth storing.

Three checks are applied in parallel: a class check against software-set enables for loads, stores and branches; a required-event check against a 16-bit mask; and a minimum-latency threshold. A record is kept only when all three pass. The decision appears one clock later with its own strobe; a kept record is forwarded to the writer in that same cycle, and a discarded one produces nothing further. Two running counters tally kept and dropped records.

Top module: `sample_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `dec_valid` and `out_valid` are low and both counters read zero.
- R2: A decision (`dec_valid` high) appears exactly one clock after each cycle with `in_valid` high, and never in a cycle following one without `in_valid`; back-to-back inputs give back-to-back decisions.
- R3: The event check passes only if every bit set in `cfg_evt_mask` is also set in `in_events`; a zero mask passes any vector. Bit meanings: bit 1 retired, bit 3 level-1 data refill, bit 5 TLB refill, bit 7 branch mispredict, bit 11 misaligned access (mask 0x80 keeps only mispredicted operations, 0x02 only retired ones).
- R4: The latency check passes when `in_latency` is greater than or equal to `cfg_min_lat`; one below the threshold fails.
- R5: Class codes are 0 other, 1 load, 2 store, 3 branch. With no class enable set every class passes; with any set, a record passes if its class has its enable set, and class 0 never passes.
- R6: `dec_keep` is high only when the class, event and latency checks all pass.
- R7: A kept record raises `out_valid` in the decision cycle with `out_class`, `out_events`, `out_latency` and `out_payload` equal to the record's inputs.
- R8: A discarded record leaves `out_valid` low.
- R9: `kept_count` or `drop_count` rises by one in the same cycle as each kept or discarded decision, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Record strobe from the collector |
| in_class | input | 2 | Operation class code |
| in_events | input | EVT_W | Event vector of the record |
| in_latency | input | LAT_W | Total latency in cycles |
| in_payload | input | PAY_W | Remaining record contents, passed through |
| cfg_only_load | input | 1 | Enable loads in the class check |
| cfg_only_store | input | 1 | Enable stores in the class check |
| cfg_only_branch | input | 1 | Enable branches in the class check |
| cfg_evt_mask | input | EVT_W | Required-event mask |
| cfg_min_lat | input | LAT_W | Minimum latency threshold |
| dec_valid | output | 1 | Decision strobe |
| dec_keep | output | 1 | Decision: 1 keep, 0 discard |
| out_valid | output | 1 | Kept record strobe to the writer |
| out_class | output | 2 | Forwarded class |
| out_events | output | EVT_W | Forwarded event vector |
| out_latency | output | LAT_W | Forwarded latency |
| out_payload | output | PAY_W | Forwarded payload |
| kept_count | output | CNT_W | Number of kept records |
| drop_count | output | CNT_W | Number of discarded records |

## Verification
Every result of this block (decision, forwarded record and both counters) is due exactly one clock edge after the input strobe, since a single register stage separates them from the inputs. The bench drives each record on a falling edge, lets one rising edge pass, and compares all outputs on the following falling edge while the next record is already applied, so back-to-back traffic is checked at the same one-cycle offset. Idle cycles are checked on the same offset to confirm that no decision appears without an input.

// File: rtl/sfilt_pkg.sv
// Shared types for the sample record filter.
package sfilt_pkg;
    // Operation class codes carried with every record.
    typedef enum logic [1:0] {
        OP_OTHER  = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STORE  = 2'd2,
        OP_BRANCH = 2'd3
    } op_class_e;
endpackage

// File: rtl/sfilt_class_check.sv
// Class check: passes when no class enable is set, or when the record's
// class has its enable set. Assumes class codes from sfilt_pkg.
module sfilt_class_check
    import sfilt_pkg::*;
(
    input  logic [1:0] cls,
    input  logic       en_load,
    input  logic       en_store,
    input  logic       en_branch,
    output logic       pass
);
    logic any_en;

    // Combine enables with the decoded class.
    always_comb begin
        any_en = en_load | en_store | en_branch;
        pass   = !any_en
               | (en_load   && (cls == OP_LOAD))
               | (en_store  && (cls == OP_STORE))
               | (en_branch && (cls == OP_BRANCH));
    end
endmodule

// File: rtl/sfilt_event_check.sv
// Event check: every mask bit that is set must also be set in the event
// vector. A zero mask passes. Purely combinational.
module sfilt_event_check #(
    parameter int EVT_W = 16
) (
    input  logic [EVT_W-1:0] events,
    input  logic [EVT_W-1:0] mask,
    output logic             pass
);
    logic [EVT_W-1:0] bit_ok;

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        // A bit is satisfied when it is not required or it is present.
        assign bit_ok[i] = !mask[i] || events[i];
    end

    assign pass = &bit_ok;
endmodule

// File: rtl/sfilt_lat_check.sv
// Latency check: passes when the total latency reaches the threshold.
// Assumes unsigned cycle counts of equal width.
module sfilt_lat_check #(
    parameter int LAT_W = 12
) (
    input  logic [LAT_W-1:0] latency,
    input  logic [LAT_W-1:0] min_lat,
    output logic             pass
);
    assign pass = (latency >= min_lat);
endmodule

// File: rtl/sfilt_counter.sv
// Event counter that increments by one per strobe, wrapping at its width.
// Synchronous active-low reset.
module sfilt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/sample_filter.sv
// Sample record filter top. Runs the class, event and latency checks in
// parallel on each input record, registers a keep/discard decision one
// cycle later, forwards kept records and counts both outcomes.
// Assumes configuration inputs are stable while records are presented.
module sample_filter #(
    parameter int EVT_W = 16,
    parameter int LAT_W = 12,
    parameter int PAY_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_class,
    input  logic [EVT_W-1:0] in_events,
    input  logic [LAT_W-1:0] in_latency,
    input  logic [PAY_W-1:0] in_payload,
    input  logic             cfg_only_load,
    input  logic             cfg_only_store,
    input  logic             cfg_only_branch,
    input  logic [EVT_W-1:0] cfg_evt_mask,
    input  logic [LAT_W-1:0] cfg_min_lat,
    output logic             dec_valid,
    output logic             dec_keep,
    output logic             out_valid,
    output logic [1:0]       out_class,
    output logic [EVT_W-1:0] out_events,
    output logic [LAT_W-1:0] out_latency,
    output logic [PAY_W-1:0] out_payload,
    output logic [CNT_W-1:0] kept_count,
    output logic [CNT_W-1:0] drop_count
);
    logic class_ok, event_ok, lat_ok, keep_now;

    sfilt_class_check u_class (
        .cls       (in_class),
        .en_load   (cfg_only_load),
        .en_store  (cfg_only_store),
        .en_branch (cfg_only_branch),
        .pass      (class_ok)
    );

    sfilt_event_check #(.EVT_W(EVT_W)) u_event (
        .events (in_events),
        .mask   (cfg_evt_mask),
        .pass   (event_ok)
    );

    sfilt_lat_check #(.LAT_W(LAT_W)) u_lat (
        .latency (in_latency),
        .min_lat (cfg_min_lat),
        .pass    (lat_ok)
    );

    assign keep_now = class_ok && event_ok && lat_ok;

    // Register the decision and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_keep  <= 1'b0;
        end else begin
            dec_valid <= in_valid;
            dec_keep  <= in_valid && keep_now;
        end
    end

    // Capture record fields for forwarding; no reset needed on data.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_class   <= in_class;
            out_events  <= in_events;
            out_latency <= in_latency;
            out_payload <= in_payload;
        end
    end

    assign out_valid = dec_valid && dec_keep;

    sfilt_counter #(.W(CNT_W)) u_kept_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (in_valid && keep_now),
        .cnt   (kept_count)
    );

    sfilt_counter #(.W(CNT_W)) u_drop_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (in_valid && !keep_now),
        .cnt   (drop_count)
    );
endmodule

// File: rtl/sfilt_checker.sv
// Temporal checks for sample_filter, attached with bind below.
module sfilt_checker #(
    parameter int EVT_W = 16,
    parameter int LAT_W = 12,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [EVT_W-1:0] in_events,
    input logic [LAT_W-1:0] in_latency,
    input logic [EVT_W-1:0] cfg_evt_mask,
    input logic [LAT_W-1:0] cfg_min_lat,
    input logic             dec_valid,
    input logic             dec_keep,
    input logic             out_valid,
    input logic [CNT_W-1:0] kept_count,
    input logic [CNT_W-1:0] drop_count
);
    AST_DEC_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dec_valid); // R2
    AST_NO_DEC_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid); // R2
    AST_MASK_MISS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((in_events & cfg_evt_mask) != cfg_evt_mask)) |=> !dec_keep); // R3
    AST_LAT_SHORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_latency < cfg_min_lat)) |=> !dec_keep); // R4
    AST_OUT_ONLY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dec_valid && dec_keep)); // R7
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_keep) |-> !out_valid); // R8
    AST_KEPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_keep) |-> (kept_count == CNT_W'($past(kept_count) + 1'b1))); // R9
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_keep) |-> (drop_count == CNT_W'($past(drop_count) + 1'b1))); // R9
endmodule

bind sample_filter sfilt_checker #(
    .EVT_W(EVT_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_events    (in_events),
    .in_latency   (in_latency),
    .cfg_evt_mask (cfg_evt_mask),
    .cfg_min_lat  (cfg_min_lat),
    .dec_valid    (dec_valid),
    .dec_keep     (dec_keep),
    .out_valid    (out_valid),
    .kept_count   (kept_count),
    .drop_count   (drop_count)
);

// File: tb/sample_filter_tb.sv
module sample_filter_tb;
    localparam int EVT_W = 16;
    localparam int LAT_W = 12;
    localparam int PAY_W = 32;
    localparam int CNT_W = 16;
    localparam int NV    = 15;

    // Vector: {ld,st,br, mask[15:0], min[11:0], class[1:0], ev[15:0], lat[11:0], keep}
    localparam logic [61:0] VEC [0:NV-1] = '{
        {3'b000, 16'h0000, 12'd0,   2'd0, 16'h0000, 12'd0,   1'b1}, // R3 R5 open
        {3'b000, 16'h0080, 12'd0,   2'd3, 16'h0080, 12'd5,   1'b1}, // R3 mispredict
        {3'b000, 16'h0080, 12'd0,   2'd3, 16'h0002, 12'd5,   1'b0}, // R3 miss
        {3'b000, 16'h0002, 12'd0,   2'd1, 16'h000A, 12'd5,   1'b1}, // R3 retired
        {3'b000, 16'h000A, 12'd0,   2'd1, 16'h0008, 12'd5,   1'b0}, // R3 partial
        {3'b000, 16'h0000, 12'd100, 2'd2, 16'h0000, 12'd100, 1'b1}, // R4 equal
        {3'b000, 16'h0000, 12'd100, 2'd2, 16'h0000, 12'd99,  1'b0}, // R4 below
        {3'b100, 16'h0000, 12'd0,   2'd1, 16'h0000, 12'd1,   1'b1}, // R5 load
        {3'b100, 16'h0000, 12'd0,   2'd2, 16'h0000, 12'd1,   1'b0}, // R5 store rejected
        {3'b101, 16'h0000, 12'd0,   2'd3, 16'h0000, 12'd1,   1'b1}, // R5 branch
        {3'b010, 16'h0000, 12'd0,   2'd0, 16'h0000, 12'd1,   1'b0}, // R5 other
        {3'b010, 16'h0000, 12'd0,   2'd2, 16'h0000, 12'd1,   1'b1}, // R5 store
        {3'b111, 16'h0820, 12'd40,  2'd1, 16'h0822, 12'd50,  1'b1}, // R6 all pass
        {3'b111, 16'h0820, 12'd40,  2'd1, 16'h0822, 12'd39,  1'b0}, // R6 lat fails
        {3'b111, 16'h0820, 12'd40,  2'd0, 16'h0822, 12'd50,  1'b0}  // R6 class fails
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_class = '0;
    logic [EVT_W-1:0] in_events = '0;
    logic [LAT_W-1:0] in_latency = '0;
    logic [PAY_W-1:0] in_payload = '0;
    logic cfg_only_load = 1'b0, cfg_only_store = 1'b0, cfg_only_branch = 1'b0;
    logic [EVT_W-1:0] cfg_evt_mask = '0;
    logic [LAT_W-1:0] cfg_min_lat = '0;
    logic dec_valid, dec_keep, out_valid;
    logic [1:0] out_class;
    logic [EVT_W-1:0] out_events;
    logic [LAT_W-1:0] out_latency;
    logic [PAY_W-1:0] out_payload;
    logic [CNT_W-1:0] kept_count, drop_count;

    int checks = 0;
    int fails = 0;
    int exp_kept = 0;
    int exp_drop = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sample_filter #(.EVT_W(EVT_W), .LAT_W(LAT_W), .PAY_W(PAY_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_events(in_events), .in_latency(in_latency), .in_payload(in_payload),
        .cfg_only_load(cfg_only_load), .cfg_only_store(cfg_only_store),
        .cfg_only_branch(cfg_only_branch), .cfg_evt_mask(cfg_evt_mask),
        .cfg_min_lat(cfg_min_lat), .dec_valid(dec_valid), .dec_keep(dec_keep),
        .out_valid(out_valid), .out_class(out_class), .out_events(out_events),
        .out_latency(out_latency), .out_payload(out_payload),
        .kept_count(kept_count), .drop_count(drop_count)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input int i);
        {cfg_only_load, cfg_only_store, cfg_only_branch} = VEC[i][61:59];
        cfg_evt_mask = VEC[i][58:43];
        cfg_min_lat  = VEC[i][42:31];
        in_class     = VEC[i][30:29];
        in_events    = VEC[i][28:13];
        in_latency   = VEC[i][12:1];
        in_payload   = 32'hA500_0000 + 32'(i);
        in_valid     = 1'b1;
    endtask

    task automatic verify(input int i);
        logic k;
        k = VEC[i][0];
        if (k) exp_kept++; else exp_drop++;
        chk("R2 dec_valid", dec_valid, 1);
        chk("R6 dec_keep", dec_keep, k);
        chk(k ? "R7 out_valid" : "R8 out_valid", out_valid, k);
        if (k) begin
            chk("R7 out_class", out_class, VEC[i][30:29]);
            chk("R7 out_events", out_events, VEC[i][28:13]);
            chk("R7 out_latency", out_latency, VEC[i][12:1]);
            chk("R7 out_payload", out_payload, 32'hA500_0000 + 32'(i));
        end
        chk("R9 kept_count", kept_count, exp_kept);
        chk("R9 drop_count", drop_count, exp_drop);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 dec_valid", dec_valid, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 kept_count", kept_count, 0);
        chk("R1 drop_count", drop_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dec_valid after release", dec_valid, 0);

        // Vector table, back to back.
        apply(0);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i + 1 < NV) apply(i + 1); else in_valid = 1'b0;
            verify(i);
        end

        // Idle: no decision without input.
        @(negedge clk);
        chk("R2 idle dec_valid", dec_valid, 0);
        chk("R8 idle out_valid", out_valid, 0);

        // Single isolated mispredict-only record with a gap after it.
        cfg_only_load = 0; cfg_only_store = 0; cfg_only_branch = 0;
        cfg_evt_mask = 16'h0080; cfg_min_lat = 12'd0;
        in_class = 2'd3; in_events = 16'hFF7F; in_latency = 12'd9;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp_drop++;
        chk("R3 all but mispredict dec_keep", dec_keep, 0);
        chk("R9 drop_count", drop_count, exp_drop);
        @(negedge clk);
        chk("R2 gap dec_valid", dec_valid, 0);

        // Reset mid-run clears counters.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 kept_count cleared", kept_count, 0);
        chk("R1 drop_count cleared", drop_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule